// File: doc/BRIEF.md
# Sampled Trigger Scheduler

This block is a clocked Moore controller placed between an environment that changes its pins at arbitrary times and a device running on the controller's clock. It watches three trigger pins and answers with level changes on four action outputs. Each action edge is placed a fixed number of whole clock cycles after the clock edge at which a trigger transition was captured. No combinational path runs from a pin to an action.

A transaction opens with a transition on the start pin. The confirm pin must follow on the same sampling edge or on the next one. Once both are seen, the first output block fires: two paired actions, then a third action one cycle later. A transition on the finish pin is then expected inside a window of edges. One cycle after it arrives, the fourth action fires and the controller goes back to idle. Any transition that breaks the timing assumptions raises a one-cycle violation pulse and drops the transaction. The violation is a late or missing confirm, a finish outside its window, or an extra start or confirm while the controller waits.

Top module: `trig_sched_ctrl`

## Requirements
- R1: Each trigger pin passes through exactly one capture register. The sampling edge of a pin transition is the first rising clock edge at which the pin holds its new level. An event is a difference between the captured level and the level captured one edge before. Rising and falling transitions count alike. All offsets below are counted in clock edges from sampling edges.
- R2: `trig_in[0]` is the start pin and `trig_in[1]` is the confirm pin. When confirm is sampled on the same edge as start, `act_out[0]` and `act_out[1]` both invert at start+2 and `act_out[2]` inverts at start+3.
- R3: The confirm may also be sampled one edge after the start, with the same output schedule as in R2. `trig_in[2]` is the finish pin. When the finish is sampled at start+k with k from 3 to 6, `act_out[3]` inverts at start+k+1.
- R4: If no confirm has been sampled by start+1, `viol` pulses after edge start+2. No action inverts in that transaction, and later confirm transitions are ignored.
- R5: If the finish is sampled at start+k with k below 3, `viol` pulses after edge start+k+1, and no action scheduled at or after that edge inverts. For k = 0 nothing inverts at all.
- R6: If no finish has been sampled by start+6, `viol` pulses after edge start+7 and `act_out[3]` never inverts.
- R7: While a transaction is open, a second start transition or a second confirm transition sampled at edge X makes `viol` pulse after edge X+1. Every action that has not yet fired is cancelled.
- R8: While idle, confirm and finish transitions have no effect on any output.
- R9: A start sampled on the same edge at which `act_out[3]` inverts opens a new transaction with the normal schedule.
- R10: A synchronous active-high `rst` clears the capture registers, the actions and `viol`, and leaves the controller idle. A transaction open when reset is raised produces no later action.
- R11: `viol` is high for exactly one cycle per violation. No action inverts on the edge that raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 3 | Asynchronous trigger pins: bit 0 start, bit 1 confirm, bit 2 finish |
| act_out | output | 4 | Registered action levels, each inverted at its scheduled edge |
| viol | output | 1 | One-cycle pulse on a broken timing assumption |

## Verification
The hardest situations to reach from the pins are coincidences on one edge. One is a new start captured on the very edge at which the fourth action fires. Another is a finish or confirm that lands exactly on the last permitted edge or one edge past it, or an extra start arriving while the first block is still pending. The stimulus describes each pin as a mask of relative edges at which it inverts. The same masks give the edges at which each output must change. This makes it possible to place transitions on any chosen edge of a transaction, including two transactions back to back, and to check every output on every edge of the run.

// File: rtl/evc_pkg.sv
package evc_pkg;

  localparam int NUM_TRIG = 3;
  localparam int NUM_ACT  = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // An action visible at offset ofs is decided in the cycle whose
  // relative index is one less, because the action flop adds a cycle.
  function automatic logic decide_now(input int unsigned rel, input int unsigned ofs);
    return (rel + 1) == ofs;
  endfunction

  function automatic logic too_early(input int unsigned rel, input int unsigned lo);
    return rel < lo;
  endfunction

  function automatic logic window_last(input int unsigned rel, input int unsigned hi);
    return rel == hi;
  endfunction

endpackage

// File: rtl/evc_sampler.sv
module evc_sampler #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] evt
);

  for (genvar k = 0; k < N; k++) begin : g_pin
    logic cap_q;
    logic old_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cap_q <= 1'b0;
        old_q <= 1'b0;
      end else begin
        cap_q <= pin[k];
        old_q <= cap_q;
      end
    end

    assign evt[k] = cap_q ^ old_q;
  end

endmodule

// File: rtl/evc_actreg.sv
module evc_actreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flip,
  output logic [N-1:0] lvl
);

  for (genvar k = 0; k < N; k++) begin : g_act
    logic lvl_q;

    always_ff @(posedge clk) begin
      if (rst)          lvl_q <= 1'b0;
      else if (flip[k]) lvl_q <= ~lvl_q;
    end

    assign lvl[k] = lvl_q;
  end

endmodule

// File: rtl/evc_sequencer.sv
module evc_sequencer
  import evc_pkg::*;
#(
  parameter int unsigned SLACK_B   = 1,
  parameter int unsigned OFS_PAIR  = 2,
  parameter int unsigned OFS_THIRD = 3,
  parameter int unsigned WIN_LO    = 3,
  parameter int unsigned WIN_HI    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] evt,
  output logic [NUM_ACT-1:0]  flip,
  output logic                viol_q
);

  localparam int CW = $clog2(WIN_HI + 1);

  seq_state_e    st_q;
  logic [CW-1:0] rel_q;
  logic          got_b_q;

  logic e_a, e_b, e_c, b_ok, in_run, in_idle;
  logic dup_a, dup_b, late_b, miss_b0, early_c, idle_c, late_c, fault;
  logic start, fire_pair, fire_third, fire_last;
  int unsigned rel;

  always_comb begin
    e_a     = evt[0];
    e_b     = evt[1];
    e_c     = evt[2];
    rel     = 32'(rel_q);
    in_run  = (st_q == ST_RUN);
    in_idle = (st_q == ST_IDLE);
    b_ok    = got_b_q | e_b;

    dup_a   = in_run & e_a;
    dup_b   = in_run & e_b & got_b_q;
    late_b  = in_run & ~b_ok & (rel >= SLACK_B);
    miss_b0 = in_idle & e_a & ~e_b & (SLACK_B == 0);
    early_c = in_run & e_c & too_early(rel, WIN_LO);
    idle_c  = in_idle & e_a & e_c;
    late_c  = in_run & ~e_c & window_last(rel, WIN_HI);
    fault   = dup_a | dup_b | late_b | miss_b0 | early_c | idle_c | late_c;

    start      = in_idle & e_a & ~fault;
    fire_pair  = in_run & ~fault & b_ok & decide_now(rel, OFS_PAIR);
    fire_third = in_run & ~fault & b_ok & decide_now(rel, OFS_THIRD);
    fire_last  = in_run & ~fault & e_c;

    flip = {fire_last, fire_third, fire_pair, fire_pair};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      rel_q   <= '0;
      got_b_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= fault;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q    <= ST_RUN;
            rel_q   <= CW'(1);
            got_b_q <= e_b;
          end
        end
        ST_RUN: begin
          if (fault | fire_last) begin
            st_q    <= ST_IDLE;
            rel_q   <= '0;
            got_b_q <= 1'b0;
          end else begin
            rel_q   <= rel_q + CW'(1);
            got_b_q <= b_ok;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6: the relative counter never runs past the end of the finish window
  a_r6_rel_bounded: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (32'(rel_q) <= WIN_HI && rel_q != '0));

  // R4: past the confirm slack, an open transaction has always seen the confirm
  a_r4_confirm_held: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && 32'(rel_q) > SLACK_B) |-> got_b_q);

  // R8: without a start event the idle state is kept and no violation follows
  a_r8_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !evt[0]) |=> (st_q == ST_IDLE && !viol_q));

  // R7: a repeated start closes the open transaction
  a_r7_dup_closes: assert property (@(posedge clk) disable iff (rst)
    dup_a |=> (st_q == ST_IDLE && viol_q));

endmodule

// File: rtl/trig_sched_ctrl.sv
module trig_sched_ctrl
  import evc_pkg::*;
#(
  parameter int unsigned SLACK_B   = 1,
  parameter int unsigned OFS_PAIR  = 2,
  parameter int unsigned OFS_THIRD = 3,
  parameter int unsigned WIN_LO    = 3,
  parameter int unsigned WIN_HI    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic [NUM_ACT-1:0]  act_out,
  output logic                viol
);

  logic [NUM_TRIG-1:0] trig_evt;
  logic [NUM_ACT-1:0]  act_flip;

  evc_sampler #(.N(NUM_TRIG)) u_sampler (
    .clk (clk),
    .rst (rst),
    .pin (trig_in),
    .evt (trig_evt)
  );

  evc_sequencer #(
    .SLACK_B   (SLACK_B),
    .OFS_PAIR  (OFS_PAIR),
    .OFS_THIRD (OFS_THIRD),
    .WIN_LO    (WIN_LO),
    .WIN_HI    (WIN_HI)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .evt    (trig_evt),
    .flip   (act_flip),
    .viol_q (viol)
  );

  evc_actreg #(.N(NUM_ACT)) u_act (
    .clk  (clk),
    .rst  (rst),
    .flip (act_flip),
    .lvl  (act_out)
  );

  // R2: the paired actions always move on the same edge
  a_r2_pair_moves: assert property (@(posedge clk) disable iff (rst)
    (act_out[0] != $past(act_out[0])) |-> (act_out[1] != $past(act_out[1])));

  // R11: no action moves on the edge that raises the violation pulse
  a_r11_quiet_on_viol: assert property (@(posedge clk) disable iff (rst)
    viol |-> (act_out == $past(act_out)));

  // R11: the violation pulse lasts a single cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    viol |=> !viol);

  // R3: the finish action never shares an edge with the third action
  a_r3_last_apart: assert property (@(posedge clk) disable iff (rst)
    (act_out[3] != $past(act_out[3])) |-> (act_out[2] == $past(act_out[2])));

endmodule

// File: tb/trig_sched_ctrl_bench.sv
module trig_sched_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] trig = 3'b000;
  logic [3:0] act;
  logic       viol;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_sched_ctrl u_trig_sched_ctrl (
    .clk     (clk),
    .rst     (rst),
    .trig_in (trig),
    .act_out (act),
    .viol    (viol)
  );

  // Bit r of a mask: the pin inverts before relative edge r (so r is its
  // sampling edge), or the output is expected to change on edge r.
  typedef struct packed {
    logic [15:0] m_start, m_conf, m_fin;
    logic [15:0] x_pair, x_third, x_last, x_viol;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{16'h0001, 16'h0001, 16'h0008, 16'h0004, 16'h0008, 16'h0010, 16'h0000, 8'd1},
    '{16'h0001, 16'h0002, 16'h0040, 16'h0004, 16'h0008, 16'h0080, 16'h0000, 8'd3},
    '{16'h0001, 16'h0001, 16'h0020, 16'h0004, 16'h0008, 16'h0040, 16'h0000, 8'd2},
    '{16'h0001, 16'h0002, 16'h0010, 16'h0004, 16'h0008, 16'h0020, 16'h0000, 8'd2},
    '{16'h0001, 16'h0004, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 8'd11},
    '{16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 8'd4},
    '{16'h0001, 16'h0001, 16'h0004, 16'h0004, 16'h0000, 16'h0000, 16'h0008, 8'd5},
    '{16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0002, 8'd5},
    '{16'h0001, 16'h0001, 16'h0080, 16'h0004, 16'h0008, 16'h0000, 16'h0080, 8'd6},
    '{16'h0001, 16'h0003, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 8'd7},
    '{16'h0011, 16'h0001, 16'h0000, 16'h0004, 16'h0008, 16'h0000, 16'h0020, 8'd7},
    '{16'h0003, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 8'd7},
    '{16'h0011, 16'h0011, 16'h0108, 16'h0044, 16'h0088, 16'h0210, 16'h0000, 8'd9},
    '{16'h0000, 16'h0002, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd8}
  };

  function automatic string req_tag(input int n);
    case (n)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    logic [3:0] prev;
    for (int r = 0; r < 14; r++) begin
      prev = act;
      trig = trig ^ {v.m_fin[r], v.m_conf[r], v.m_start[r]};
      @(posedge clk); #2;
      check(tag, "act0 change", int'(act[0] != prev[0]), int'(v.x_pair[r]));
      check(tag, "act1 change", int'(act[1] != prev[1]), int'(v.x_pair[r]));
      check(tag, "act2 change", int'(act[2] != prev[2]), int'(v.x_third[r]));
      check(tag, "act3 change", int'(act[3] != prev[3]), int'(v.x_last[r]));
      check(tag, "viol",        int'(viol),              int'(v.x_viol[r]));
    end
    repeat (2) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
    summary();
    $finish;
  end

  initial begin
    // R10: state under and after reset
    repeat (3) @(posedge clk);
    #2;
    check("R10", "act under reset", int'(act), 0);
    check("R10", "viol under reset", int'(viol), 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check("R10", "act after release", int'(act), 0);
    check("R10", "viol after release", int'(viol), 0);

    // R10: reset in the middle of an open transaction
    trig = 3'b011;
    @(posedge clk); #2;
    @(posedge clk); #2;
    rst  = 1'b1;
    trig = 3'b000;
    @(posedge clk); #2;
    @(posedge clk); #2;
    check("R10", "act cleared mid-run", int'(act), 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2;
      check("R10", "act after abandoned run", int'(act), 0);
      check("R10", "viol after abandoned run", int'(viol), 0);
    end

    // table walk: R1..R9, R11
    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], req_tag(int'(VEC[i].req)));
    end

    summary();
    $finish;
  end

endmodule